// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Generator

This block serves the acknowledge cycle of a two-level interrupt scheme in which a primary eight-input controller has a secondary eight-input controller hanging off one of its request lines (the cascade line, line 2). When the processor strobes an acknowledge, the block looks at the winner and valid outputs that both controllers' priority resolvers present. It forms the 8-bit interrupt vector and tells each controller how to update its in-service, request and rotation state.

The vector is the controller's base, held as its upper five bits, with the three-bit line number in the lower bits. A winner on the cascade line hands the vector to the secondary controller. A missing winner, on either level, produces the spurious line 7 and does not raise a fault. Each controller may run in automatic end-of-interrupt mode, optionally with priority rotation. Lines flagged as level-triggered keep their request pending through the acknowledge.

All results are registered. They appear one clock after the strobe, together with a one-cycle done pulse. The vector is then held until the next acknowledge.

Top module: `intack_vec_gen`

## Requirements
- R1: When the primary has a valid winner on a line other than 2, the vector is {mst_base, line} (bits 7:3 base, bits 2:0 line). Only the primary is acknowledged, on that line.
- R2: When the primary winner is line 2 and the secondary has a valid winner, the vector is {slv_base, secondary line}. The secondary is acknowledged on its line and the primary on line 2.
- R3: When the primary winner is line 2 and the secondary has no valid winner, the vector is {slv_base, 7}. The primary is acknowledged on line 2 and the secondary is not acknowledged.
- R4: When the primary has no valid winner, the vector is {mst_base, 7} and neither controller is acknowledged.
- R5: vec_out and vec_done change at the first rising edge after ack_req is sampled high. vec_done is high for exactly the cycles that follow a strobe cycle. vec_out holds its value until the next strobe.
- R6: For an acknowledged controller with automatic end-of-interrupt off, the set-in-service mask is one-hot at the acknowledged line (bit n = line n).
- R7: For an acknowledged controller with automatic end-of-interrupt on, the set-in-service mask is zero. If rotation is also on, the rotate write strobe is high and the new priority base is (line + 1) mod 8. Otherwise the strobe is low and the base output is 0.
- R8: The clear-request mask of an acknowledged controller has the line's bit set only when that line's level bit is 0 (edge-triggered). A line whose level bit is 1 gets no clear.
- R9: After reset, every output is 0.
- R10: In a cycle following one without ack_req, vec_done, both acknowledge pulses and all update masks and strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| mst_vld | input | 1 | Primary resolver has a winner |
| mst_line | input | 3 | Primary winning line |
| slv_vld | input | 1 | Secondary resolver has a winner |
| slv_line | input | 3 | Secondary winning line |
| mst_base | input | 5 | Primary vector base, upper five bits |
| slv_base | input | 5 | Secondary vector base, upper five bits |
| mst_auto_eoi | input | 1 | Primary automatic end-of-interrupt mode |
| mst_rot_eoi | input | 1 | Primary rotate on automatic end-of-interrupt |
| slv_auto_eoi | input | 1 | Secondary automatic end-of-interrupt mode |
| slv_rot_eoi | input | 1 | Secondary rotate on automatic end-of-interrupt |
| mst_level | input | 8 | Primary level-triggered line flags |
| slv_level | input | 8 | Secondary level-triggered line flags |
| vec_out | output | 8 | Interrupt vector, held between acknowledges |
| vec_done | output | 1 | Vector valid pulse |
| mst_ack | output | 1 | Primary acknowledge pulse |
| mst_ack_line | output | 3 | Primary acknowledged line |
| mst_set_isr | output | 8 | Primary in-service set mask |
| mst_clr_irr | output | 8 | Primary request clear mask |
| mst_rot_we | output | 1 | Primary priority-base write strobe |
| mst_rot_base | output | 3 | Primary new priority base |
| slv_ack | output | 1 | Secondary acknowledge pulse |
| slv_ack_line | output | 3 | Secondary acknowledged line |
| slv_set_isr | output | 8 | Secondary in-service set mask |
| slv_clr_irr | output | 8 | Secondary request clear mask |
| slv_rot_we | output | 1 | Secondary priority-base write strobe |
| slv_rot_base | output | 3 | Secondary new priority base |

## Verification
The bench drives the cascade line with and without a secondary winner. A design that skipped the primary acknowledge there would leave line 2 never in service, and one that acknowledged a phantom secondary line would corrupt that controller's state. It uses line 7 with rotation to catch a base that fails to wrap to 0, and level-flagged lines to catch a request clear that would drop a still-asserted level input. Cycles without a strobe and back-to-back strobes expose a done pulse that lingers, a vector that drifts while idle, and update strobes that fire without an acknowledge.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int LINE_W = 3;
  localparam int NLINES = 1 << LINE_W;
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - LINE_W;
  localparam int NCTL   = 2;
  localparam int MST    = 0;
  localparam int SLV    = 1;

  typedef struct packed {
    logic              ack;
    logic [LINE_W-1:0] line;
    logic [NLINES-1:0] set_isr;
    logic [NLINES-1:0] clr_irr;
    logic              rot_we;
    logic [LINE_W-1:0] rot_base;
  } ack_upd_t;
endpackage

// File: rtl/intack_route.sv
module intack_route
  import intack_pkg::*;
#(
  parameter int CASC_LINE = 2,
  parameter int SPUR_LINE = NLINES - 1
) (
  input  logic              mst_vld,
  input  logic [LINE_W-1:0] mst_line,
  input  logic              slv_vld,
  input  logic [LINE_W-1:0] slv_line,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  output logic [VEC_W-1:0]  vec,
  output logic              take_mst,
  output logic              take_slv
);
  localparam logic [LINE_W-1:0] CASC = LINE_W'(CASC_LINE);
  localparam logic [LINE_W-1:0] SPUR = LINE_W'(SPUR_LINE);

  always_comb begin
    take_mst = 1'b0;
    take_slv = 1'b0;
    vec      = {mst_base, SPUR};
    if (mst_vld) begin
      take_mst = 1'b1;
      if (mst_line == CASC) begin
        if (slv_vld) begin
          take_slv = 1'b1;
          vec      = {slv_base, slv_line};
        end else begin
          vec      = {slv_base, SPUR};
        end
      end else begin
        vec = {mst_base, mst_line};
      end
    end
  end
endmodule

// File: rtl/intack_side.sv
module intack_side
  import intack_pkg::*;
(
  input  logic              ack_en,
  input  logic [LINE_W-1:0] line,
  input  logic              auto_eoi,
  input  logic              rot_eoi,
  input  logic [NLINES-1:0] level,
  output ack_upd_t          upd
);
  logic [NLINES-1:0] line_oh;

  always_comb begin
    line_oh      = '0;
    line_oh[line] = 1'b1;
    upd          = '0;
    if (ack_en) begin
      upd.ack     = 1'b1;
      upd.line    = line;
      upd.clr_irr = line_oh & ~level;
      if (auto_eoi) begin
        if (rot_eoi) begin
          upd.rot_we   = 1'b1;
          upd.rot_base = line + LINE_W'(1);
        end
      end else begin
        upd.set_isr = line_oh;
      end
    end
  end
endmodule

// File: rtl/intack_vec_gen.sv
module intack_vec_gen
  import intack_pkg::*;
#(
  parameter int CASC_LINE = 2,
  parameter int SPUR_LINE = NLINES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req,
  input  logic              mst_vld,
  input  logic [LINE_W-1:0] mst_line,
  input  logic              slv_vld,
  input  logic [LINE_W-1:0] slv_line,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  input  logic              mst_auto_eoi,
  input  logic              mst_rot_eoi,
  input  logic              slv_auto_eoi,
  input  logic              slv_rot_eoi,
  input  logic [NLINES-1:0] mst_level,
  input  logic [NLINES-1:0] slv_level,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_done,
  output logic              mst_ack,
  output logic [LINE_W-1:0] mst_ack_line,
  output logic [NLINES-1:0] mst_set_isr,
  output logic [NLINES-1:0] mst_clr_irr,
  output logic              mst_rot_we,
  output logic [LINE_W-1:0] mst_rot_base,
  output logic              slv_ack,
  output logic [LINE_W-1:0] slv_ack_line,
  output logic [NLINES-1:0] slv_set_isr,
  output logic [NLINES-1:0] slv_clr_irr,
  output logic              slv_rot_we,
  output logic [LINE_W-1:0] slv_rot_base
);
  logic [VEC_W-1:0]  route_vec;
  logic              take_mst, take_slv;
  logic [NCTL-1:0]   side_en;
  logic [LINE_W-1:0] side_line [NCTL];
  logic [NCTL-1:0]   side_aeoi, side_rot;
  logic [NLINES-1:0] side_level [NCTL];
  ack_upd_t          upd_d [NCTL];
  ack_upd_t          upd_q [NCTL];
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic              done_d, done_q;

  intack_route #(.CASC_LINE(CASC_LINE), .SPUR_LINE(SPUR_LINE)) u_route (
    .mst_vld  (mst_vld),
    .mst_line (mst_line),
    .slv_vld  (slv_vld),
    .slv_line (slv_line),
    .mst_base (mst_base),
    .slv_base (slv_base),
    .vec      (route_vec),
    .take_mst (take_mst),
    .take_slv (take_slv)
  );

  assign side_en[MST]    = ack_req & take_mst;
  assign side_en[SLV]    = ack_req & take_slv;
  assign side_line[MST]  = mst_line;
  assign side_line[SLV]  = slv_line;
  assign side_aeoi       = {slv_auto_eoi, mst_auto_eoi};
  assign side_rot        = {slv_rot_eoi, mst_rot_eoi};
  assign side_level[MST] = mst_level;
  assign side_level[SLV] = slv_level;

  for (genvar g = 0; g < NCTL; g++) begin : g_side
    intack_side u_side (
      .ack_en   (side_en[g]),
      .line     (side_line[g]),
      .auto_eoi (side_aeoi[g]),
      .rot_eoi  (side_rot[g]),
      .level    (side_level[g]),
      .upd      (upd_d[g])
    );
  end

  // next state: vector captured only on a strobe, done follows the strobe
  always_comb begin
    vec_d  = vec_q;
    done_d = ack_req;
    if (ack_req) vec_d = route_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < NCTL; i++) upd_q[i] <= '0;
    end else begin
      vec_q  <= vec_d;
      done_q <= done_d;
      for (int i = 0; i < NCTL; i++) upd_q[i] <= upd_d[i];
    end
  end

  assign vec_out      = vec_q;
  assign vec_done     = done_q;
  assign mst_ack      = upd_q[MST].ack;
  assign mst_ack_line = upd_q[MST].line;
  assign mst_set_isr  = upd_q[MST].set_isr;
  assign mst_clr_irr  = upd_q[MST].clr_irr;
  assign mst_rot_we   = upd_q[MST].rot_we;
  assign mst_rot_base = upd_q[MST].rot_base;
  assign slv_ack      = upd_q[SLV].ack;
  assign slv_ack_line = upd_q[SLV].line;
  assign slv_set_isr  = upd_q[SLV].set_isr;
  assign slv_clr_irr  = upd_q[SLV].clr_irr;
  assign slv_rot_we   = upd_q[SLV].rot_we;
  assign slv_rot_base = upd_q[SLV].rot_base;

  // R5
  p_done_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> vec_done);
  // R5
  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> $stable(vec_out));
  // R10
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> (!vec_done && !mst_ack && !slv_ack && !mst_rot_we && !slv_rot_we));
  // R2
  p_slave_needs_cascade_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ack |-> (mst_ack && mst_ack_line == LINE_W'(CASC_LINE)));
  // R6
  p_isr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_set_isr) && $onehot0(slv_set_isr));
  // R7
  p_aeoi_no_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && mst_auto_eoi) |=> (mst_set_isr == '0));
  // R8
  p_level_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ((mst_clr_irr & $past(mst_level)) == '0));
endmodule

// File: tb/intack_vec_gen_bench.sv
module intack_vec_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_req = 1'b0;
  logic       mst_vld = 1'b0, slv_vld = 1'b0;
  logic [2:0] mst_line = '0, slv_line = '0;
  logic [4:0] mst_base = '0, slv_base = '0;
  logic       mst_auto_eoi = 1'b0, mst_rot_eoi = 1'b0;
  logic       slv_auto_eoi = 1'b0, slv_rot_eoi = 1'b0;
  logic [7:0] mst_level = '0, slv_level = '0;
  logic [7:0] vec_out;
  logic       vec_done;
  logic       mst_ack, slv_ack, mst_rot_we, slv_rot_we;
  logic [2:0] mst_ack_line, slv_ack_line, mst_rot_base, slv_rot_base;
  logic [7:0] mst_set_isr, mst_clr_irr, slv_set_isr, slv_clr_irr;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intack_vec_gen u_intack_vec_gen (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
    .mst_vld(mst_vld), .mst_line(mst_line), .slv_vld(slv_vld), .slv_line(slv_line),
    .mst_base(mst_base), .slv_base(slv_base),
    .mst_auto_eoi(mst_auto_eoi), .mst_rot_eoi(mst_rot_eoi),
    .slv_auto_eoi(slv_auto_eoi), .slv_rot_eoi(slv_rot_eoi),
    .mst_level(mst_level), .slv_level(slv_level),
    .vec_out(vec_out), .vec_done(vec_done),
    .mst_ack(mst_ack), .mst_ack_line(mst_ack_line), .mst_set_isr(mst_set_isr),
    .mst_clr_irr(mst_clr_irr), .mst_rot_we(mst_rot_we), .mst_rot_base(mst_rot_base),
    .slv_ack(slv_ack), .slv_ack_line(slv_ack_line), .slv_set_isr(slv_set_isr),
    .slv_clr_irr(slv_clr_irr), .slv_rot_we(slv_rot_we), .slv_rot_base(slv_rot_base)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mkvec(logic [4:0] b, logic [2:0] l);
    return {b, l};
  endfunction

  // raise the strobe for one cycle; return at the negedge after the capturing edge
  task automatic strobe();
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 vec_out", vec_out, 0);
    chk("R9 vec_done", vec_done, 0);
    chk("R9 acks", {mst_ack, slv_ack, mst_rot_we, slv_rot_we}, 0);
    chk("R9 masks", {mst_set_isr, mst_clr_irr, slv_set_isr, slv_clr_irr}, 0);
  endtask

  task automatic t_master_line();
    mst_vld = 1; mst_line = 3'd5; mst_base = 5'h01; slv_vld = 1; slv_line = 3'd4;
    strobe();
    chk("R1 vec", vec_out, mkvec(5'h01, 3'd5));
    chk("R5 done", vec_done, 1);
    chk("R1 mst_ack", {mst_ack, mst_ack_line}, {1'b1, 3'd5});
    chk("R1 slv_ack", slv_ack, 0);
    chk("R6 set_isr", mst_set_isr, 8'h20);
    chk("R8 clr_irr edge", mst_clr_irr, 8'h20);
    mst_line = 3'd1;
    @(negedge clk);
    chk("R5 done single", vec_done, 0);
    chk("R5 vec held", vec_out, mkvec(5'h01, 3'd5));
    chk("R10 no ack idle", {mst_ack, mst_set_isr, mst_clr_irr}, 0);
  endtask

  task automatic t_cascade();
    mst_vld = 1; mst_line = 3'd2; slv_vld = 1; slv_line = 3'd3; slv_base = 5'h0E;
    strobe();
    chk("R2 vec", vec_out, mkvec(5'h0E, 3'd3));
    chk("R2 mst_ack", {mst_ack, mst_ack_line}, {1'b1, 3'd2});
    chk("R2 slv_ack", {slv_ack, slv_ack_line}, {1'b1, 3'd3});
    chk("R6 slv set_isr", slv_set_isr, 8'h08);
    chk("R6 mst set_isr", mst_set_isr, 8'h04);
  endtask

  task automatic t_cascade_spur();
    mst_vld = 1; mst_line = 3'd2; slv_vld = 0; slv_line = 3'd3; slv_base = 5'h0E;
    strobe();
    chk("R3 vec", vec_out, mkvec(5'h0E, 3'd7));
    chk("R3 mst_ack", {mst_ack, mst_ack_line}, {1'b1, 3'd2});
    chk("R3 slv not acked", {slv_ack, slv_set_isr, slv_clr_irr}, 0);
  endtask

  task automatic t_none();
    mst_vld = 0; mst_line = 3'd4; slv_vld = 1; mst_base = 5'h01;
    strobe();
    chk("R4 vec", vec_out, mkvec(5'h01, 3'd7));
    chk("R4 done", vec_done, 1);
    chk("R4 no acks", {mst_ack, slv_ack, mst_set_isr, slv_set_isr}, 0);
  endtask

  task automatic t_level();
    mst_vld = 1; mst_line = 3'd4; mst_level = 8'h10;
    strobe();
    chk("R8 level kept", mst_clr_irr, 8'h00);
    chk("R6 level isr", mst_set_isr, 8'h10);
    mst_level = 8'hEF;
    strobe();
    chk("R8 edge cleared", mst_clr_irr, 8'h10);
    mst_level = 8'h00;
  endtask

  task automatic t_aeoi();
    mst_vld = 1; mst_line = 3'd7; mst_auto_eoi = 1; mst_rot_eoi = 1;
    strobe();
    chk("R7 no isr", mst_set_isr, 0);
    chk("R7 rot wrap", {mst_rot_we, mst_rot_base}, {1'b1, 3'd0});
    mst_line = 3'd1; mst_rot_eoi = 0;
    strobe();
    chk("R7 no rot", {mst_rot_we, mst_rot_base, mst_set_isr}, 0);
    chk("R8 aeoi clr", mst_clr_irr, 8'h02);
    mst_auto_eoi = 0;
    mst_line = 3'd2; slv_vld = 1; slv_line = 3'd6; slv_auto_eoi = 1; slv_rot_eoi = 1;
    strobe();
    chk("R7 slv rot", {slv_rot_we, slv_rot_base, slv_set_isr}, {1'b1, 3'd7, 8'h00});
    chk("R6 mst isr cascade", mst_set_isr, 8'h04);
    slv_auto_eoi = 0; slv_rot_eoi = 0;
  endtask

  task automatic t_idle();
    mst_vld = 1; mst_line = 3'd3; mst_base = 5'h1F;
    repeat (3) @(negedge clk);
    chk("R10 idle done", vec_done, 0);
    chk("R10 idle acks", {mst_ack, slv_ack, mst_clr_irr, mst_set_isr}, 0);
  endtask

  task automatic t_back_to_back();
    mst_vld = 1; mst_line = 3'd0; mst_base = 5'h02;
    @(negedge clk);
    ack_req = 1;
    @(negedge clk);
    chk("R5 b2b first", vec_out, mkvec(5'h02, 3'd0));
    mst_line = 3'd6;
    @(negedge clk);
    ack_req = 0;
    chk("R5 b2b done", vec_done, 1);
    chk("R1 b2b second", vec_out, mkvec(5'h02, 3'd6));
    @(negedge clk);
    chk("R5 b2b drop", vec_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_master_line();
    t_cascade();
    t_cascade_spur();
    t_none();
    t_level();
    t_aeoi();
    t_idle();
    t_back_to_back();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule